// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Engine

This block is the receive side of one DMA channel. A client offers a stream of data chunks. Each chunk carries up to one data word, a byte count and an end-of-packet marker. The engine writes the accepted bytes into memory buffers that a linked list of in-memory descriptors describes. Each descriptor has four words at consecutive word offsets: next-descriptor pointer (+0), buffer start (+1 word), flag word (+2 words) and buffer end (+3 words). In the flag word, bit 0 marks the last descriptor of the list, bit 4 asks for an interrupt, and the engine sets bit 11 when a packet ended inside that buffer.

A start pulse gives the engine the address of the first descriptor and the address of a context word. The engine then reads the four descriptor words and fills the buffer from its start address. It closes the descriptor when the buffer is full or when a chunk carries end-of-packet. On close it rewrites the flag and buffer-end words, where buffer end becomes the actual fill point. It then sets raw interrupt bits and either follows the next pointer or, on the last descriptor, writes the disable bit into the context word and halts. While halted, offered chunks are consumed with zero bytes taken.

Memory is a plain request port. A request is accepted in the cycle it is raised. Read data returns in the following cycle.

Top module: `rxdma_chain`

## Requirements
- R1: Out of reset, s_ready_o is 0, mem_req_o is 0, irq_raw_o is 0, irq_upd_o is 0 and halted_o is 0.
- R2: A start pulse makes the engine issue four word reads, at the descriptor address plus 0, 4, 8 and 12 bytes, on consecutive cycles.
- R3: For each accepted chunk the engine takes the smaller of (buffer end minus current position) and s_len_i. It reports this count on s_acc_len_o during the handshake. If the count is nonzero, it writes s_data_i to the current position in the same cycle, with mem_bytes_o equal to the count. The position then advances by the count.
- R4: A descriptor closes when the position reaches buffer end. An empty buffer closes on its first chunk with zero bytes taken.
- R5: A chunk with end-of-packet closes the descriptor early. The buffer-end word written back (descriptor + 12) holds the final fill position.
- R6: On end-of-packet close, the flag word written back (descriptor + 8) has bit 11 set, and raw interrupt bit 3 is set.
- R7: On close of a descriptor whose flag bit 4 is set, raw interrupt bits 0 and 1 are set. Raw bits stay set until reset.
- R8: irq_upd_o pulses for one cycle, the cycle after the closing handshake, only when that close changed irq_raw_o.
- R9: On close of a descriptor whose flag bit 0 is clear, the engine fetches the descriptor at the next pointer and fills from its buffer start.
- R10: On close of a descriptor whose flag bit 0 is set, the engine writes the value with only bit 15 set to the context address and then raises halted_o. A later start pulse clears halted_o and begins a new fetch.
- R11: While halted, s_ready_o is 1, s_acc_len_o is 0 and no memory request is made for an offered chunk.
- R12: s_ready_o is 0 while a descriptor is being fetched or written back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle or halted |
| start_desc_i | input | ADDR_W | Byte address of the first descriptor |
| start_ctx_i | input | ADDR_W | Byte address of the context word |
| s_valid_i | input | 1 | A chunk is offered |
| s_ready_o | output | 1 | The engine consumes the offered chunk this cycle |
| s_data_i | input | DATA_W | Chunk data, low bytes first |
| s_len_i | input | LEN_W | Bytes offered in the chunk |
| s_eop_i | input | 1 | Chunk ends a packet |
| s_acc_len_o | output | LEN_W | Bytes taken from the offered chunk |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_bytes_o | output | LEN_W | Bytes written, or a full word for reads |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the read request |
| irq_raw_o | output | 4 | Sticky raw interrupt bits |
| irq_upd_o | output | 1 | One-cycle strobe when the raw bits changed |
| halted_o | output | 1 | End of list reached |

## Verification
The checks assume that the client holds a chunk steady until it is consumed and never offers more bytes than a data word holds. They also assume memory answers every read exactly one cycle later and never stalls a request. The stimulus drives chunks one cycle after the clock edge and holds them until s_ready_o is seen. It keeps s_len_i between 0 and 4. The bench memory model returns registered read data on every cycle. Descriptor buffers are placed so that the buffer end is never below the buffer start, which keeps the remaining-space subtraction from wrapping.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STREAM,
    ST_WB_FLAGS,
    ST_WB_END,
    ST_CTX,
    ST_HALT
  } rx_state_e;

  localparam int DESC_WORDS = 4;
  localparam int FLG_LAST   = 0;
  localparam int FLG_INTR   = 4;
  localparam int FLG_INEOP  = 11;
  localparam int CTX_DIS    = 15;
  localparam int RAW_W      = 4;

  // raw interrupt bits raised by one descriptor close
  function automatic logic [RAW_W-1:0] close_bits(input logic want_intr, input logic saw_eop);
    logic [RAW_W-1:0] b;
    b = '0;
    if (want_intr) b[1:0] = 2'b11;
    if (saw_eop)   b[3]   = 1'b1;
    return b;
  endfunction

endpackage

// File: rtl/rxdma_fill.sv
module rxdma_fill #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] pos_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic [LEN_W-1:0]  offer_i,
  input  logic              eop_i,
  input  logic              halted_i,
  output logic [LEN_W-1:0]  take_o,
  output logic [ADDR_W-1:0] next_pos_o,
  output logic              close_o
);

  function automatic logic [ADDR_W-1:0] take_of(input logic [ADDR_W-1:0] room,
                                                input logic [ADDR_W-1:0] offer);
    return (room < offer) ? room : offer;
  endfunction

  logic [ADDR_W-1:0] room_w;
  logic [ADDR_W-1:0] take_w;

  always_comb begin
    room_w     = end_i - pos_i;
    take_w     = halted_i ? '0 : take_of(room_w, ADDR_W'(offer_i));
    take_o     = take_w[LEN_W-1:0];
    next_pos_o = pos_i + take_w;
    close_o    = !halted_i && ((next_pos_o == end_i) || eop_i);
  end

endmodule

// File: rtl/rxdma_irq.sv
module rxdma_irq
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en_i,
  input  logic [RAW_W-1:0] set_bits_i,
  output logic [RAW_W-1:0] raw_o,
  output logic             upd_o
);

  logic [RAW_W-1:0] merged_w;
  assign merged_w = raw_o | set_bits_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_o <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= set_en_i && (merged_w != raw_o);
      if (set_en_i) raw_o <= merged_w;
    end
  end

endmodule

// File: rtl/rxdma_chain.sv
module rxdma_chain
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int WORD_B = DATA_W / 8,
  localparam int LEN_W  = $clog2(WORD_B) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_desc_i,
  input  logic [ADDR_W-1:0] start_ctx_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic [LEN_W-1:0]  s_len_i,
  input  logic              s_eop_i,
  output logic [LEN_W-1:0]  s_acc_len_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [LEN_W-1:0]  mem_bytes_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [RAW_W-1:0]  irq_raw_o,
  output logic              irq_upd_o,
  output logic              halted_o
);

  localparam int CNT_W = $clog2(DESC_WORDS + 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] desc_q, ctx_q, next_q, buf_q, end_q, pos_q;
  logic [DATA_W-1:0] flags_q;
  logic              eop_q;

  logic              hs_w;
  logic              desc_done_w;
  logic              data_wr_w;
  logic              fill_close_w;
  logic [LEN_W-1:0]  take_w;
  logic [ADDR_W-1:0] next_pos_w;

  rxdma_fill #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) fill_i (
    .pos_i      (pos_q),
    .end_i      (end_q),
    .offer_i    (s_len_i),
    .eop_i      (s_eop_i),
    .halted_i   (state_q == ST_HALT),
    .take_o     (take_w),
    .next_pos_o (next_pos_w),
    .close_o    (fill_close_w)
  );

  assign s_ready_o   = (state_q == ST_STREAM) || (state_q == ST_HALT);
  assign s_acc_len_o = take_w;
  assign hs_w        = s_valid_i && s_ready_o;
  assign desc_done_w = hs_w && (state_q == ST_STREAM) && fill_close_w;
  assign data_wr_w   = hs_w && (state_q == ST_STREAM) && (take_w != '0);
  assign halted_o    = (state_q == ST_HALT);

  rxdma_irq irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en_i   (desc_done_w),
    .set_bits_i (close_bits(flags_q[FLG_INTR], s_eop_i)),
    .raw_o      (irq_raw_o),
    .upd_o      (irq_upd_o)
  );

  // memory request mux
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_bytes_o = LEN_W'(WORD_B);
    unique case (state_q)
      ST_FETCH: begin
        mem_req_o  = (cnt_q < CNT_W'(DESC_WORDS));
        mem_addr_o = desc_q + ADDR_W'(cnt_q) * ADDR_W'(WORD_B);
      end
      ST_STREAM: begin
        mem_req_o   = data_wr_w;
        mem_we_o    = 1'b1;
        mem_addr_o  = pos_q;
        mem_wdata_o = s_data_i;
        mem_bytes_o = take_w;
      end
      ST_WB_FLAGS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + ADDR_W'(2 * WORD_B);
        mem_wdata_o = flags_q | (DATA_W'(eop_q) << FLG_INEOP);
      end
      ST_WB_END: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + ADDR_W'(3 * WORD_B);
        mem_wdata_o = DATA_W'(end_q);
      end
      ST_CTX: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_q;
        mem_wdata_o = DATA_W'(1) << CTX_DIS;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      desc_q  <= '0;
      ctx_q   <= '0;
      next_q  <= '0;
      buf_q   <= '0;
      end_q   <= '0;
      pos_q   <= '0;
      flags_q <= '0;
      eop_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HALT: begin
          if (start_i) begin
            desc_q  <= start_desc_i;
            ctx_q   <= start_ctx_i;
            cnt_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          unique case (cnt_q)
            CNT_W'(1): next_q  <= ADDR_W'(mem_rdata_i);
            CNT_W'(2): buf_q   <= ADDR_W'(mem_rdata_i);
            CNT_W'(3): flags_q <= mem_rdata_i;
            CNT_W'(4): end_q   <= ADDR_W'(mem_rdata_i);
            default: ;
          endcase
          if (cnt_q == CNT_W'(DESC_WORDS)) begin
            pos_q   <= buf_q;
            cnt_q   <= '0;
            state_q <= ST_STREAM;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STREAM: begin
          if (hs_w) begin
            pos_q <= next_pos_w;
            if (fill_close_w) begin
              eop_q   <= s_eop_i;
              end_q   <= next_pos_w;
              state_q <= ST_WB_FLAGS;
            end
          end
        end
        ST_WB_FLAGS: state_q <= ST_WB_END;
        ST_WB_END: begin
          if (flags_q[FLG_LAST]) begin
            state_q <= ST_CTX;
          end else begin
            desc_q  <= next_q;
            cnt_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_CTX: state_q <= ST_HALT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxdma_chain_chk.sv
module rxdma_chain_chk
  import rxdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic [LEN_W-1:0]  s_len_i,
  input logic [LEN_W-1:0]  s_acc_len_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [RAW_W-1:0]  irq_raw_o,
  input logic              irq_upd_o,
  input logic              halted_o,
  input logic              desc_done_w
);

  AST_HALT_TAKES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o && s_valid_i |-> !mem_req_o && (s_acc_len_o == '0)); // R11

  AST_TAKE_WITHIN_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid_i && s_ready_o |-> s_acc_len_o <= s_len_i); // R3

  AST_NO_READY_DURING_DESC_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !(s_valid_i && s_ready_o) |-> !s_ready_o); // R12

  AST_RAW_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_raw_o) & ~irq_raw_o) == '0); // R7

  AST_STROBE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_upd_o |-> irq_raw_o != $past(irq_raw_o)); // R8

  AST_CHANGE_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raw_o != $past(irq_raw_o) |-> irq_upd_o); // R8

  AST_HALT_AFTER_CONTEXT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_o) |-> $past(mem_req_o && mem_we_o && mem_wdata_o[CTX_DIS])); // R10

  AST_CLOSE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done_w |=> !s_ready_o); // R4

endmodule

bind rxdma_chain rxdma_chain_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/rxdma_chain_tb.sv
module rxdma_chain_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_desc = '0;
  logic [31:0] start_ctx = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic [2:0]  s_len = '0;
  logic        s_eop = 1'b0;
  logic [2:0]  s_acc;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [2:0]  mem_bytes;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  irq_raw;
  logic        irq_upd;
  logic        halted;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxdma_chain dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_desc_i(start_desc),
    .start_ctx_i(start_ctx), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .s_data_i(s_data), .s_len_i(s_len), .s_eop_i(s_eop), .s_acc_len_o(s_acc),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_bytes_o(mem_bytes), .mem_rdata_i(mem_rdata),
    .irq_raw_o(irq_raw), .irq_upd_o(irq_upd), .halted_o(halted)
  );

  logic [31:0] mem_arr [64];
  always @(posedge clk) mem_rdata <= mem_arr[mem_addr[7:2]];

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [2:0]  bytes;
  } req_t;

  req_t exp_q[$];
  req_t mon_e;

  int n_cmp = 0;
  int n_bad = 0;
  int got_upd = 0;
  int exp_upd = 0;
  logic [3:0]  exp_raw = '0;
  logic [31:0] m_desc, m_next, m_pos, m_end, m_flags, m_ctx;
  bit          m_halt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every memory request is compared against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_upd) got_upd++;
      if (mem_req) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected memory request", mem_addr, 32'hFFFF_FFFF);
        end else begin
          mon_e = exp_q.pop_front();
          chk(mem_we == mon_e.we, "R2 request direction", {31'd0, mem_we}, {31'd0, mon_e.we});
          chk(mem_addr == mon_e.addr, "R9 request address", mem_addr, mon_e.addr);
          if (mon_e.we) begin
            chk(mem_wdata == mon_e.data, "R5 write data", mem_wdata, mon_e.data);
            chk(mem_bytes == mon_e.bytes, "R3 write byte count", {29'd0, mem_bytes}, {29'd0, mon_e.bytes});
          end
        end
      end
    end
  end

  task automatic load_desc(input logic [31:0] a);
    for (int i = 0; i < 4; i++) exp_q.push_back('{1'b0, a + 32'(4 * i), 32'd0, 3'd4});
    m_desc  = a;
    m_next  = mem_arr[a[7:2]];
    m_pos   = mem_arr[a[7:2] + 6'd1];
    m_flags = mem_arr[a[7:2] + 6'd2];
    m_end   = mem_arr[a[7:2] + 6'd3];
  endtask

  task automatic begin_chain(input logic [31:0] d, input logic [31:0] c);
    load_desc(d);
    m_ctx  = c;
    m_halt = 0;
    @(posedge clk); #1;
    start = 1'b1; start_desc = d; start_ctx = c;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(s_ready == 1'b0, "R12 ready during fetch", {31'd0, s_ready}, 32'd0);
  endtask

  task automatic send(input logic [31:0] d, input logic [2:0] len, input bit eop, input string tag);
    logic [31:0] room, accx, npos;
    logic [3:0]  nraw;
    bit          done;
    room = m_end - m_pos;
    accx = (room < {29'd0, len}) ? room : {29'd0, len};
    if (m_halt) accx = 0;
    npos = m_pos + accx;
    done = !m_halt && ((npos == m_end) || eop);
    if (accx != 0) exp_q.push_back('{1'b1, m_pos, d, accx[2:0]});
    if (done) begin
      exp_q.push_back('{1'b1, m_desc + 32'd8, m_flags | (eop ? 32'h800 : 32'h0), 3'd4});
      exp_q.push_back('{1'b1, m_desc + 32'd12, npos, 3'd4});
      nraw = exp_raw | (m_flags[4] ? 4'h3 : 4'h0) | (eop ? 4'h8 : 4'h0);
      if (nraw != exp_raw) exp_upd++;
      exp_raw = nraw;
      if (m_flags[0]) begin
        exp_q.push_back('{1'b1, m_ctx, 32'h8000, 3'd4});
        m_halt = 1;
      end else begin
        load_desc(m_next);
      end
    end else begin
      m_pos = npos;
    end
    @(posedge clk); #1;
    s_valid = 1'b1; s_data = d; s_len = len; s_eop = eop;
    do @(negedge clk); while (!s_ready);
    chk(s_acc == accx[2:0], tag, {29'd0, s_acc}, accx);
    @(posedge clk); #1;
    s_valid = 1'b0;
    @(negedge clk);
    if (done) chk(s_ready == 1'b0, "R12 ready during write-back", {31'd0, s_ready}, 32'd0);
    chk(irq_raw == exp_raw, "R7 raw interrupt bits", {28'd0, irq_raw}, {28'd0, exp_raw});
  endtask

  task automatic put_desc(input int w, input logic [31:0] nx, input logic [31:0] bf,
                          input logic [31:0] fl, input logic [31:0] en);
    mem_arr[w] = nx; mem_arr[w+1] = bf; mem_arr[w+2] = fl; mem_arr[w+3] = en;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_arr[i] = '0;
    put_desc(0,  32'h10, 32'h100, 32'h10, 32'h10A); // intr, 10 bytes
    put_desc(4,  32'h20, 32'h200, 32'h00, 32'h210);
    put_desc(8,  32'h30, 32'h300, 32'h10, 32'h308);
    put_desc(12, 32'h00, 32'h400, 32'h11, 32'h400); // last, empty buffer
    put_desc(16, 32'h00, 32'h500, 32'h01, 32'h504); // last

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_ready == 1'b0, "R1 ready in reset", {31'd0, s_ready}, 32'd0);
    chk(mem_req == 1'b0, "R1 no request in reset", {31'd0, mem_req}, 32'd0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(irq_raw == 4'h0, "R1 raw after reset", {28'd0, irq_raw}, 32'd0);
    chk(halted == 1'b0, "R1 halted after reset", {31'd0, halted}, 32'd0);
    chk(irq_upd == 1'b0, "R1 strobe after reset", {31'd0, irq_upd}, 32'd0);

    begin_chain(32'h00, 32'hF0);
    send(32'hA1A2A3A4, 3'd4, 0, "R3 full chunk");
    send(32'hB1B2B3B4, 3'd4, 0, "R3 second chunk");
    send(32'hC1C2C3C4, 3'd4, 0, "R4 truncated to room, buffer full");
    send(32'hD1D2D3D4, 3'd3, 1, "R5 early end-of-packet");
    send(32'hE1E2E3E4, 3'd4, 0, "R9 next descriptor");
    send(32'hF1F2F3F4, 3'd4, 0, "R8 close with no raw change");
    send(32'h01020304, 3'd2, 1, "R4 empty buffer closes");
    repeat (4) @(negedge clk);
    chk(halted == 1'b1, "R10 halted at end of list", {31'd0, halted}, 32'd1);
    send(32'h55555555, 3'd4, 0, "R11 zero bytes taken while halted");
    chk(halted == 1'b1, "R11 still halted", {31'd0, halted}, 32'd1);

    begin_chain(32'h40, 32'hE0);
    chk(halted == 1'b0, "R10 restart clears halt", {31'd0, halted}, 32'd0);
    send(32'h11223344, 3'd4, 0, "R3 chunk after restart");
    repeat (4) @(negedge clk);
    chk(halted == 1'b1, "R10 halted again", {31'd0, halted}, 32'd1);
    chk(exp_q.size() == 0, "R9 all expected requests seen", exp_q.size(), 32'd0);
    chk(got_upd == exp_upd, "R8 strobe count", got_upd, exp_upd);
    chk(irq_raw == 4'hB, "R6 raw with end-of-packet bit", {28'd0, irq_raw}, 32'hB);
    finish_run();
  end

endmodule